// File: doc/BRIEF.md
# Operand Bypass and Hazard Controller

This block is the hazard control for a five-stage in-order pipeline whose stages are fetch, decode, operand fetch, execute and write. A clocked latch separates each pair of stages, and instructions enter one cycle apart. Each cycle the block looks at the source register numbers of the instruction in operand fetch. It compares them with the destinations of the older instructions still in execute and in write. From that comparison it produces, registered into the execute stage, a select code for each ALU operand multiplexer. The select picks the register file, the latched ALU result buffer or the incoming memory data bus.

The register file returns a value written in the same cycle. The result buffer holds the result of the instruction now in write. Load data appears on the memory bus in the cycle after the load leaves execute, and it is too late for an operand whose consumer sits directly behind the load. That consumer is therefore held in operand fetch for one bubble cycle. It then takes the word from the bus.

Branches are recognised in decode and resolved in execute. While a branch is in decode, operand fetch or execute, the latch from fetch to decode takes a bubble and the fetch address is frozen. In the resolve cycle the block supplies the next fetch address: the target for a taken branch, the branch address plus 4 otherwise. A saturating count of stall cycles is exposed.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After a synchronous active-low reset both operand selects read 0 (register file), `stall_cnt` is 0 and `hold_front` is low.
- R2: Operand select codes are 0 register file, 1 ALU result buffer, 2 load data bus. A valid operand-fetch source that is nonzero and matches the destination of a valid, writing, non-load instruction in execute gives select 1 one clock later.
- R3: A nonzero source that matches a valid, writing load in write, with no match in execute, gives select 2 one clock later.
- R4: A nonzero source of a valid operand-fetch instruction that matches a valid, writing load in execute raises `hold_front` and `bubble_x` in that same cycle. `pc_next` then equals `pc_cur`, and both selects are 0 one clock later.
- R5: When execute and write both write the matched register, execute wins. An ALU producer there gives select 1, and a load producer there gives a stall.
- R6: Source register 0 never forwards or stalls, and an instruction whose write flag is low never forwards or stalls.
- R7: A match only against a non-load instruction in write gives select 0, because the register file writes through.
- R8: While a valid branch is in decode or operand fetch, `kill_fd` is high and `pc_next` equals `pc_cur`.
- R9: With a valid branch in execute, `kill_fd` is high. `pc_next` is `x_target` if `x_taken` is set, else `x_pc` + 4.
- R10: With no hazard and no branch in flight, `pc_next` is `pc_cur` + 4 and `kill_fd` and `hold_front` are low.
- R11: `stall_cnt` rises by one for each cycle with a load stall or a branch in flight, and it saturates at its maximum.
- R12: A stage whose valid flag is low causes no forward, no stall and no fetch freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_cur | input | PC_W | Current fetch address |
| d_valid | input | 1 | Decode stage holds an instruction |
| d_branch | input | 1 | Decode instruction is a branch |
| o_valid | input | 1 | Operand-fetch stage holds an instruction |
| o_branch | input | 1 | Operand-fetch instruction is a branch |
| o_src | input | NSRC x REG_W | Source register numbers in operand fetch |
| x_valid | input | 1 | Execute stage holds an instruction |
| x_wr | input | 1 | Execute instruction writes a register |
| x_load | input | 1 | Execute instruction is a load |
| x_rd | input | REG_W | Execute destination register |
| x_branch | input | 1 | Execute instruction is a branch |
| x_taken | input | 1 | Branch in execute is taken |
| x_pc | input | PC_W | Address of the instruction in execute |
| x_target | input | PC_W | Resolved branch target |
| w_valid | input | 1 | Write stage holds an instruction |
| w_wr | input | 1 | Write instruction writes a register |
| w_load | input | 1 | Write instruction is a load |
| w_rd | input | REG_W | Write destination register |
| sel_x | output | NSRC x 2 | Registered operand select codes for execute |
| hold_front | output | 1 | Hold fetch, decode and operand fetch |
| bubble_x | output | 1 | Insert a bubble into execute |
| kill_fd | output | 1 | Load a bubble into the fetch-to-decode latch |
| pc_next | output | PC_W | Next fetch address |
| stall_cnt | output | CNT_W | Saturating stall-cycle count |

## Verification
`hold_front`, `bubble_x`, `kill_fd` and `pc_next` are combinational on the stage records. The bench drives each pattern on a falling edge and reads those outputs 1 ns later, in the same cycle. The operand selects are registered, so they are read 1 ns after the next rising edge, with the pattern still applied. `stall_cnt` is read on the falling edge after the rising edge that counts the stalled cycle. Each stimulus row and each directed case therefore samples exactly the cycle in which its result is due.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
// hz_pkg: shared encodings for the hazard controller.
// Assumes byte addressing with 4-byte instructions.
package hz_pkg;
    typedef enum logic [1:0] {
        OPSEL_REGFILE = 2'd0,
        OPSEL_RESBUF  = 2'd1,
        OPSEL_LOADBUS = 2'd2
    } opsel_e;

    localparam int unsigned PC_STEP = 4;
endpackage

// File: rtl/hz_src_resolve.sv
`timescale 1ns/1ps
// hz_src_resolve: decides the bypass source for one operand-fetch source.
// Assumes the register file writes through, so an ALU producer in the
// write stage needs no bypass. Register 0 is never a hazard source.
module hz_src_resolve
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             x_valid,
    input  logic             x_wr,
    input  logic             x_load,
    input  logic [REG_W-1:0] x_rd,
    input  logic             w_valid,
    input  logic             w_wr,
    input  logic             w_load,
    input  logic [REG_W-1:0] w_rd,
    output opsel_e           sel,
    output logic             load_hazard
);
    logic src_live;
    logic x_hit;
    logic w_hit;

    // Match the source against the two older in-flight destinations.
    always_comb begin
        src_live = (src != '0);
        x_hit    = src_live && x_valid && x_wr && (x_rd == src);
        w_hit    = src_live && w_valid && w_wr && w_load && (w_rd == src);
    end

    // The youngest producer (execute) takes precedence over write.
    always_comb begin
        sel         = OPSEL_REGFILE;
        load_hazard = 1'b0;
        if (x_hit) begin
            if (x_load) load_hazard = 1'b1;
            else        sel         = OPSEL_RESBUF;
        end else if (w_hit) begin
            sel = OPSEL_LOADBUS;
        end
    end
endmodule

// File: rtl/hz_branch_ctl.sv
`timescale 1ns/1ps
// hz_branch_ctl: freezes fetch while a branch is in flight and picks
// the next fetch address. Assumes branches resolve in execute and that
// the address in execute is the branch's own address.
module hz_branch_ctl
    import hz_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            d_valid,
    input  logic            d_branch,
    input  logic            o_valid,
    input  logic            o_branch,
    input  logic            x_valid,
    input  logic            x_branch,
    input  logic            x_taken,
    input  logic [PC_W-1:0] x_pc,
    input  logic [PC_W-1:0] x_target,
    input  logic [PC_W-1:0] pc_cur,
    input  logic            hold_front,
    output logic            kill_fd,
    output logic            fetch_block,
    output logic [PC_W-1:0] pc_next
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    logic br_early;
    logic br_resolve;

    // Locate a branch in decode, operand fetch or execute.
    always_comb begin
        br_early    = (d_valid && d_branch) || (o_valid && o_branch);
        br_resolve  = x_valid && x_branch;
        fetch_block = br_early || br_resolve;
        kill_fd     = fetch_block;
    end

    // Next fetch address: redirect first, then freeze, then sequential.
    always_comb begin
        if (br_resolve)
            pc_next = x_taken ? x_target : (x_pc + STEP);
        else if (br_early || hold_front)
            pc_next = pc_cur;
        else
            pc_next = pc_cur + STEP;
    end
endmodule

// File: rtl/hz_stall_counter.sv
`timescale 1ns/1ps
// hz_stall_counter: saturating count of stall cycles.
// Assumes one increment request per cycle at most.
module hz_stall_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up on each stall cycle and stop at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                        count <= '0;
        else if (inc && (count != CNT_MAX)) count <= count + 1'b1;
    end
endmodule

// File: rtl/pipe_hazard_unit.sv
`timescale 1ns/1ps
// pipe_hazard_unit: operand bypass selection, load-use stall and branch
// fetch control for a five-stage in-order pipeline. The stage records
// are the outputs of the datapath's inter-stage latches. Selects are
// registered into the execute stage alongside the operand latch.
module pipe_hazard_unit
    import hz_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NSRC  = 2,
    parameter int PC_W  = 32,
    parameter int CNT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PC_W-1:0]            pc_cur,
    input  logic                       d_valid,
    input  logic                       d_branch,
    input  logic                       o_valid,
    input  logic                       o_branch,
    input  logic [NSRC-1:0][REG_W-1:0] o_src,
    input  logic                       x_valid,
    input  logic                       x_wr,
    input  logic                       x_load,
    input  logic [REG_W-1:0]           x_rd,
    input  logic                       x_branch,
    input  logic                       x_taken,
    input  logic [PC_W-1:0]            x_pc,
    input  logic [PC_W-1:0]            x_target,
    input  logic                       w_valid,
    input  logic                       w_wr,
    input  logic                       w_load,
    input  logic [REG_W-1:0]           w_rd,
    output logic [NSRC-1:0][1:0]       sel_x,
    output logic                       hold_front,
    output logic                       bubble_x,
    output logic                       kill_fd,
    output logic [PC_W-1:0]            pc_next,
    output logic [CNT_W-1:0]           stall_cnt
);
    opsel_e          sel_now [NSRC];
    opsel_e          sel_q   [NSRC];
    logic [NSRC-1:0] src_stall;
    logic            load_use;
    logic            fetch_block;

    // One resolver per operand source.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hz_src_resolve #(.REG_W(REG_W)) u_res (
            .src         (o_src[g]),
            .x_valid     (x_valid),
            .x_wr        (x_wr),
            .x_load      (x_load),
            .x_rd        (x_rd),
            .w_valid     (w_valid),
            .w_wr        (w_wr),
            .w_load      (w_load),
            .w_rd        (w_rd),
            .sel         (sel_now[g]),
            .load_hazard (src_stall[g])
        );
        assign sel_x[g] = sel_q[g];
    end

    // A load-use hit holds the front end and bubbles execute.
    always_comb begin
        load_use   = o_valid && (|src_stall);
        hold_front = load_use;
        bubble_x   = load_use;
    end

    // Register the selects for the instruction that enters execute.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSRC; i++) begin
            if (!rst_n)
                sel_q[i] <= OPSEL_REGFILE;
            else if (o_valid && !load_use)
                sel_q[i] <= sel_now[i];
            else
                sel_q[i] <= OPSEL_REGFILE;
        end
    end

    hz_branch_ctl #(.PC_W(PC_W)) u_br (
        .d_valid     (d_valid),
        .d_branch    (d_branch),
        .o_valid     (o_valid),
        .o_branch    (o_branch),
        .x_valid     (x_valid),
        .x_branch    (x_branch),
        .x_taken     (x_taken),
        .x_pc        (x_pc),
        .x_target    (x_target),
        .pc_cur      (pc_cur),
        .hold_front  (hold_front),
        .kill_fd     (kill_fd),
        .fetch_block (fetch_block),
        .pc_next     (pc_next)
    );

    hz_stall_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (load_use || fetch_block),
        .count (stall_cnt)
    );
endmodule

// File: rtl/hz_checker.sv
`timescale 1ns/1ps
// hz_checker: temporal properties of pipe_hazard_unit, bound to it below.
// Assumes reset is held for at least one clock before release.
module hz_checker #(
    parameter int REG_W = 5,
    parameter int NSRC  = 2,
    parameter int PC_W  = 32,
    parameter int CNT_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [PC_W-1:0]            pc_cur,
    input logic                       d_valid,
    input logic                       d_branch,
    input logic                       o_valid,
    input logic [NSRC-1:0][REG_W-1:0] o_src,
    input logic                       x_valid,
    input logic                       x_wr,
    input logic                       x_load,
    input logic [REG_W-1:0]           x_rd,
    input logic                       x_branch,
    input logic                       x_taken,
    input logic [PC_W-1:0]            x_target,
    input logic                       w_valid,
    input logic                       w_wr,
    input logic                       w_load,
    input logic [REG_W-1:0]           w_rd,
    input logic [NSRC-1:0][1:0]       sel_x,
    input logic                       hold_front,
    input logic                       kill_fd,
    input logic [PC_W-1:0]            pc_next,
    input logic [CNT_W-1:0]           stall_cnt
);
    logic armed;

    // Becomes set one clock after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        AST_SEL_ENCODING: assert property (@(posedge clk) disable iff (!rst_n)
            sel_x[g] != 2'd3); // R2
        AST_RESBUF_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n || !armed)
            (sel_x[g] == 2'd1) |-> $past(o_valid && x_valid && x_wr && !x_load
                                         && (x_rd == o_src[g]))); // R2
        AST_LOADBUS_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
            (sel_x[g] == 2'd2) |-> $past(w_valid && w_wr && w_load
                                         && (w_rd == o_src[g]))); // R3
        AST_STALL_CLEARS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
            hold_front |=> (sel_x[g] == 2'd0)); // R4
        AST_ZERO_SRC_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
            (o_src[g] == '0) |=> (sel_x[g] == 2'd0)); // R6
    end

    AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_front |-> (o_valid && x_valid && x_wr && x_load)); // R4
    AST_REDIRECT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && x_branch && x_taken) |-> (pc_next == x_target)); // R9
    AST_FETCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_branch && !(x_valid && x_branch)) |-> (kill_fd && pc_next == pc_cur)); // R8
    AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        stall_cnt >= $past(stall_cnt)); // R11
endmodule

bind pipe_hazard_unit hz_checker #(
    .REG_W(REG_W), .NSRC(NSRC), .PC_W(PC_W), .CNT_W(CNT_W)
) u_hz_chk (
    .clk(clk), .rst_n(rst_n), .pc_cur(pc_cur), .d_valid(d_valid),
    .d_branch(d_branch), .o_valid(o_valid), .o_src(o_src),
    .x_valid(x_valid), .x_wr(x_wr), .x_load(x_load), .x_rd(x_rd),
    .x_branch(x_branch), .x_taken(x_taken), .x_target(x_target),
    .w_valid(w_valid), .w_wr(w_wr), .w_load(w_load), .w_rd(w_rd),
    .sel_x(sel_x), .hold_front(hold_front), .kill_fd(kill_fd),
    .pc_next(pc_next), .stall_cnt(stall_cnt)
);

// File: tb/tb_pipe_hazard_unit.sv
`timescale 1ns/1ps
// tb_pipe_hazard_unit: table-driven bypass checks, then directed tests
// of reset, fetch control and the stall counter.
module tb_pipe_hazard_unit;
    localparam int REG_W = 5;
    localparam int NSRC  = 2;
    localparam int PC_W  = 32;
    localparam int CNT_W = 8;

    logic                       clk = 1'b0;
    logic                       rst_n;
    logic [PC_W-1:0]            pc_cur;
    logic                       d_valid, d_branch, o_valid, o_branch;
    logic [NSRC-1:0][REG_W-1:0] o_src;
    logic                       x_valid, x_wr, x_load, x_branch, x_taken;
    logic [REG_W-1:0]           x_rd;
    logic [PC_W-1:0]            x_pc, x_target;
    logic                       w_valid, w_wr, w_load;
    logic [REG_W-1:0]           w_rd;
    logic [NSRC-1:0][1:0]       sel_x;
    logic                       hold_front, bubble_x, kill_fd;
    logic [PC_W-1:0]            pc_next;
    logic [CNT_W-1:0]           stall_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pipe_hazard_unit #(.REG_W(REG_W), .NSRC(NSRC), .PC_W(PC_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .pc_cur(pc_cur), .d_valid(d_valid),
        .d_branch(d_branch), .o_valid(o_valid), .o_branch(o_branch),
        .o_src(o_src), .x_valid(x_valid), .x_wr(x_wr), .x_load(x_load),
        .x_rd(x_rd), .x_branch(x_branch), .x_taken(x_taken), .x_pc(x_pc),
        .x_target(x_target), .w_valid(w_valid), .w_wr(w_wr),
        .w_load(w_load), .w_rd(w_rd), .sel_x(sel_x),
        .hold_front(hold_front), .bubble_x(bubble_x), .kill_fd(kill_fd),
        .pc_next(pc_next), .stall_cnt(stall_cnt)
    );

    typedef struct packed {
        logic       ov;
        logic [4:0] sa;
        logic [4:0] sb;
        logic       xv, xw, xl;
        logic [4:0] xr;
        logic       wv, ww, wl;
        logic [4:0] wr;
        logic       eh;
        logic [1:0] ea, eb;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        // R2: ALU producer in execute
        '{1'b1, 5'd3, 5'd4,  1'b1, 1'b1, 1'b0, 5'd3,  1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 2'd1, 2'd0, 4'd2},
        // R3: load in write
        '{1'b1, 5'd4, 5'd7,  1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 5'd4,  1'b0, 2'd2, 2'd0, 4'd3},
        // R4: load in execute stalls
        '{1'b1, 5'd5, 5'd1,  1'b1, 1'b1, 1'b1, 5'd5,  1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 2'd0, 2'd0, 4'd4},
        // R5: youngest ALU beats older load
        '{1'b1, 5'd6, 5'd6,  1'b1, 1'b1, 1'b0, 5'd6,  1'b1, 1'b1, 1'b1, 5'd6,  1'b0, 2'd1, 2'd1, 4'd5},
        // R6: register 0
        '{1'b1, 5'd0, 5'd0,  1'b1, 1'b1, 1'b0, 5'd0,  1'b1, 1'b1, 1'b1, 5'd0,  1'b0, 2'd0, 2'd0, 4'd6},
        // R6: no destination in execute
        '{1'b1, 5'd9, 5'd9,  1'b1, 1'b0, 1'b0, 5'd9,  1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 2'd0, 2'd0, 4'd6},
        // R6: non-writing loads
        '{1'b1, 5'd9, 5'd2,  1'b1, 1'b0, 1'b1, 5'd9,  1'b1, 1'b0, 1'b1, 5'd2,  1'b0, 2'd0, 2'd0, 4'd6},
        // R7: ALU in write uses register file
        '{1'b1, 5'd8, 5'd1,  1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 1'b1, 1'b0, 5'd8,  1'b0, 2'd0, 2'd0, 4'd7},
        // R12: bubble in operand fetch
        '{1'b0, 5'd3, 5'd3,  1'b1, 1'b1, 1'b1, 5'd3,  1'b1, 1'b1, 1'b1, 5'd3,  1'b0, 2'd0, 2'd0, 4'd12},
        // R12: bubble in execute
        '{1'b1, 5'd3, 5'd3,  1'b0, 1'b1, 1'b0, 5'd3,  1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 2'd0, 2'd0, 4'd12},
        // R5: youngest load beats older load, stall
        '{1'b1, 5'd2, 5'd2,  1'b1, 1'b1, 1'b1, 5'd2,  1'b1, 1'b1, 1'b1, 5'd2,  1'b1, 2'd0, 2'd0, 4'd5},
        // R2: mixed sources, one per path
        '{1'b1, 5'd12, 5'd11, 1'b1, 1'b1, 1'b0, 5'd11, 1'b1, 1'b1, 1'b1, 5'd12, 1'b0, 2'd2, 2'd1, 4'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        pc_cur = 32'h100; d_valid = 0; d_branch = 0; o_valid = 0; o_branch = 0;
        o_src = '0; x_valid = 0; x_wr = 0; x_load = 0; x_rd = '0; x_branch = 0;
        x_taken = 0; x_pc = '0; x_target = '0; w_valid = 0; w_wr = 0;
        w_load = 0; w_rd = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_use_on();
        o_valid = 1; o_src[0] = 5'd5; x_valid = 1; x_wr = 1; x_load = 1; x_rd = 5'd5;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle();
        do_reset();
        // R1: reset state
        chk("R1 selA", 32'(sel_x[0]), 32'd0);
        chk("R1 selB", 32'(sel_x[1]), 32'd0);
        chk("R1 cnt", 32'(stall_cnt), 32'd0);
        chk("R1 hold", 32'(hold_front), 32'd0);

        // Table walk: hold in the same cycle, selects after the next edge.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            o_valid = VT[i].ov; o_src[0] = VT[i].sa; o_src[1] = VT[i].sb;
            x_valid = VT[i].xv; x_wr = VT[i].xw; x_load = VT[i].xl; x_rd = VT[i].xr;
            w_valid = VT[i].wv; w_wr = VT[i].ww; w_load = VT[i].wl; w_rd = VT[i].wr;
            #1;
            chk($sformatf("R%0d hold row %0d", VT[i].req, i), 32'(hold_front), 32'(VT[i].eh));
            chk($sformatf("R%0d bubble row %0d", VT[i].req, i), 32'(bubble_x), 32'(VT[i].eh));
            @(posedge clk); #1;
            chk($sformatf("R%0d selA row %0d", VT[i].req, i), 32'(sel_x[0]), 32'(VT[i].ea));
            chk($sformatf("R%0d selB row %0d", VT[i].req, i), 32'(sel_x[1]), 32'(VT[i].eb));
        end

        // Fetch control, combinational.
        @(negedge clk); idle(); #1;
        chk("R10 pc_next", pc_next, 32'h104);
        chk("R10 kill", 32'(kill_fd), 32'd0);
        chk("R10 hold", 32'(hold_front), 32'd0);
        d_valid = 1; d_branch = 1; #1;
        chk("R8 decode kill", 32'(kill_fd), 32'd1);
        chk("R8 decode pc", pc_next, 32'h100);
        idle(); o_valid = 1; o_branch = 1; #1;
        chk("R8 opfetch kill", 32'(kill_fd), 32'd1);
        chk("R8 opfetch pc", pc_next, 32'h100);
        idle(); x_valid = 1; x_branch = 1; x_taken = 1; x_pc = 32'hF8; x_target = 32'h2000; #1;
        chk("R9 taken pc", pc_next, 32'h2000);
        chk("R9 taken kill", 32'(kill_fd), 32'd1);
        x_taken = 0; #1;
        chk("R9 not taken pc", pc_next, 32'hFC);
        idle(); load_use_on(); #1;
        chk("R4 pc held", pc_next, 32'h100);
        idle(); d_branch = 1; #1;
        chk("R12 invalid branch kill", 32'(kill_fd), 32'd0);
        chk("R12 invalid branch pc", pc_next, 32'h104);

        // Stall counter.
        do_reset();
        chk("R1 cnt after reset", 32'(stall_cnt), 32'd0);
        load_use_on();
        repeat (3) @(negedge clk);
        idle();
        @(negedge clk);
        chk("R11 three load stalls", 32'(stall_cnt), 32'd3);
        d_valid = 1; d_branch = 1;
        @(negedge clk);
        idle();
        @(negedge clk);
        chk("R11 branch stall", 32'(stall_cnt), 32'd4);
        load_use_on();
        repeat (300) @(negedge clk);
        chk("R11 saturate", 32'(stall_cnt), 32'd255);
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule